// File: doc/BRIEF.md
# Receive Frame Rule-Table Classifier

This block decides what happens to each received frame. It holds a table of 256 programmable rules. Each rule pairs a 13-bit control word with a 32-bit constant. When a frame arrives, header logic upstream has already extracted 16 properties of 32 bits each. The block walks the table from the lowest entry upward and stops at the first rule whose comparison holds. That rule either rejects the frame or files it to one of 64 virtual receive queues. The queue is then mapped to a physical receive ring, and the frame is discarded if that ring is switched off.

Two table entries are evaluated per clock, so a full pass over the table takes 128 cycles. The control FSM has three states:

- IDLE waits for a frame.
- SEARCH steps through the entry pairs.
- REPORT presents a one-cycle result strobe.

The transitions are:

- *start-filter* (IDLE→SEARCH) is taken on a frame start while filtering is on.
- *start-bypass* (IDLE→REPORT) is taken on a frame start while filtering is off.
- *step* (SEARCH→SEARCH) is taken when the current pair has no hit and it is not the last pair.
- *resolve* (SEARCH→REPORT) is taken on a hit or after the last pair.
- *release* (REPORT→IDLE) is always taken after the strobe.

Software programs the table through an index register and two data-write strobes. The contents at the current index can always be read back. Data writes are parked in a pending slot and reach the table only while the FSM is in IDLE.

Top module: `rx_rule_classifier`

## Requirements
- R1: After reset, `res_valid` is 0 and every table entry reads back as zero (control word and constant).
- R2: The search visits entries in ascending order and the first matching entry alone decides the outcome. When both entries of a pair match, the even (lower) entry wins.
- R3: Define the start edge as the clock edge that samples `frame_start`. With filtering on, a first match in entry e raises `res_valid` in the cycle after clock edge floor(e/2)+1 counted from the start edge. A frame with no match raises it after edge 128.
- R4: Control bits [3:0] pick the property index and bits [5:4] pick the operator: 0 means equal, 1 not equal, 2 unsigned property ≥ constant, 3 unsigned property < constant.
- R5: When control bit [6] of the matching rule is 1, the frame is rejected: `res_accept`=0, `res_queue`=0, `res_ring`=0 and both error flags are 0.
- R6: When bit [6] is 0, the frame is filed to queue bits [12:7] and `res_queue` shows all 6 bits. With `map_mode`=0 the ring is the low three queue bits; with `map_mode`=1 the ring is always 0.
- R7: A filed frame whose ring has a 0 in `ring_en` gives `res_accept`=0 and `res_fiq_err`=1. An accepted frame never carries either error flag.
- R8: When no entry matches, the result is `res_nomatch`=1, `res_accept`=0, queue 0 and ring 0.
- R9: With `filer_en`=0, a frame goes straight to queue 0 and ring 0, and the strobe comes in the cycle after the start edge. The ring 0 enable check of R7 still applies.
- R10: `idx_wr` loads the index register. `ctrl_wr` stores `wr_data[12:0]` as the control word and `prop_wr` stores `wr_data` as the constant, both at the index. `rd_ctrl` returns the stored control word with bits above 12 read as zero, and `rd_prop` returns the stored constant.
- R11: A data write issued during a search leaves the running search unchanged and takes effect once the block is idle.
- R12: A `frame_start` pulse that arrives while a search or result is in progress is dropped; it produces no result of its own.
- R13: `res_valid` is high for exactly one cycle per accepted frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse when a frame's properties are valid |
| frame_props | input | 16×32 | Extracted frame properties, element i is property i |
| filer_en | input | 1 | 1 = search the table, 0 = send every frame to queue 0 |
| map_mode | input | 1 | 0 = ring from low queue bits, 1 = every queue on ring 0 |
| ring_en | input | 8 | Per-ring enable mask |
| idx_wr | input | 1 | Load the table index register |
| idx_data | input | 8 | New table index |
| ctrl_wr | input | 1 | Write the control word at the index |
| prop_wr | input | 1 | Write the constant at the index |
| wr_data | input | 32 | Write data for both data strobes |
| rd_ctrl | output | 32 | Control word at the index, upper bits zero |
| rd_prop | output | 32 | Constant at the index |
| res_valid | output | 1 | One-cycle result strobe |
| res_accept | output | 1 | Frame accepted into a ring |
| res_queue | output | 6 | Virtual queue of a filed frame |
| res_ring | output | 3 | Physical ring of a filed frame |
| res_fiq_err | output | 1 | Filed to a disabled ring, frame discarded |
| res_nomatch | output | 1 | No rule matched, frame discarded |

## Verification
The bench goes after pair priority: two matching entries share a pair and carry opposite outcomes. A design that let the odd entry win, or that searched the pair in the wrong order, would return the reject instead of the filed queue. The operators are driven exactly at their boundaries: a property equal to the constant, one below it, and an all-ones value. This exposes a signed compare or a ≥/< mix-up, which would flip the hit on the equal value. Strobe latency is compared for a first-entry hit, a last-entry hit and an empty search, so an off-by-one in pair stepping shows up as a shifted strobe. A table write landed during a search, and a second frame start arriving mid-search, must both leave the running result untouched. A design that wrote through at once or restarted on the new pulse would report the newer rule or the wrong queue.

// File: rtl/rxcls_pkg.sv
package rxcls_pkg;
    localparam int N_PROPS = 16;
    localparam int PID_W   = 4;
    localparam int QID_W   = 6;
    localparam int CTRL_W  = 13;

    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_NE = 2'd1,
        CMP_GE = 2'd2,
        CMP_LT = 2'd3
    } cmp_op_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SEARCH = 2'd1,
        S_REPORT = 2'd2
    } srch_state_e;

    // Packed MSB first: qid [12:7], reject [6], op [5:4], pid [3:0]
    typedef struct packed {
        logic [QID_W-1:0] qid;
        logic             reject;
        cmp_op_e          op;
        logic [PID_W-1:0] pid;
    } rule_ctrl_t;
endpackage

// File: rtl/rxcls_rule_eval.sv
module rxcls_rule_eval import rxcls_pkg::*; #(
    parameter int PROP_W = 32
) (
    input  logic [PID_W-1:0]                 pid,
    input  cmp_op_e                          op,
    input  logic [PROP_W-1:0]                konst,
    input  logic [N_PROPS-1:0][PROP_W-1:0]   props,
    output logic                             hit
);
    logic [PROP_W-1:0] sel;

    always_comb begin
        sel = props[pid];
        unique case (op)
            CMP_EQ:  hit = (sel == konst);
            CMP_NE:  hit = (sel != konst);
            CMP_GE:  hit = (sel >= konst);
            CMP_LT:  hit = (sel <  konst);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/rxcls_queue_map.sv
module rxcls_queue_map #(
    parameter int RING_N = 8,
    localparam int RING_W = $clog2(RING_N)
) (
    input  logic [RING_W-1:0] qid_low,
    input  logic              single_ring,
    input  logic [RING_N-1:0] ring_en,
    output logic [RING_W-1:0] ring,
    output logic              ring_ok
);
    always_comb begin
        ring    = single_ring ? '0 : qid_low;
        ring_ok = ring_en[ring];
    end
endmodule

// File: rtl/rxcls_rule_table.sv
module rxcls_rule_table import rxcls_pkg::*; #(
    parameter int N_ENTRIES = 256,
    parameter int PROP_W    = 32,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        idle,
    input  logic                        idx_wr,
    input  logic [IDX_W-1:0]            idx_data,
    input  logic                        ctrl_wr,
    input  logic [CTRL_W-1:0]           ctrl_wdata,
    input  logic                        prop_wr,
    input  logic [PROP_W-1:0]           prop_wdata,
    output logic [CTRL_W-1:0]           rd_ctrl,
    output logic [PROP_W-1:0]           rd_prop,
    input  logic [1:0][IDX_W-1:0]       look_idx,
    output rule_ctrl_t [1:0]            look_ctrl,
    output logic [1:0][PROP_W-1:0]      look_prop
);
    rule_ctrl_t        ctrl_mem [N_ENTRIES];
    logic [PROP_W-1:0] prop_mem [N_ENTRIES];

    logic [IDX_W-1:0]  idx_q;
    logic              pc_q, pp_q;
    logic [IDX_W-1:0]  pc_idx_q, pp_idx_q;
    rule_ctrl_t        pc_dat_q;
    logic [PROP_W-1:0] pp_dat_q;

    // Storage: pending writes land only while the searcher is idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                ctrl_mem[i] <= '0;
                prop_mem[i] <= '0;
            end
        end else if (idle) begin
            if (pc_q) ctrl_mem[pc_idx_q] <= pc_dat_q;
            if (pp_q) prop_mem[pp_idx_q] <= pp_dat_q;
        end
    end

    // Index register and pending write slots
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            pc_q     <= 1'b0;
            pp_q     <= 1'b0;
            pc_idx_q <= '0;
            pp_idx_q <= '0;
            pc_dat_q <= '0;
            pp_dat_q <= '0;
        end else begin
            if (idx_wr) idx_q <= idx_data;
            if (ctrl_wr) begin
                pc_q     <= 1'b1;
                pc_idx_q <= idx_q;
                pc_dat_q <= rule_ctrl_t'(ctrl_wdata);
            end else if (idle) begin
                pc_q <= 1'b0;
            end
            if (prop_wr) begin
                pp_q     <= 1'b1;
                pp_idx_q <= idx_q;
                pp_dat_q <= prop_wdata;
            end else if (idle) begin
                pp_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_ctrl = ctrl_mem[idx_q];
        rd_prop = prop_mem[idx_q];
        for (int l = 0; l < 2; l++) begin
            look_ctrl[l] = ctrl_mem[look_idx[l]];
            look_prop[l] = prop_mem[look_idx[l]];
        end
    end

    assert_ctrl_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && pc_q) |=> pc_q)
        else $error("pending control write dropped during search");

    assert_prop_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && pp_q) |=> pp_q)
        else $error("pending constant write dropped during search");
endmodule

// File: rtl/rx_rule_classifier.sv
module rx_rule_classifier import rxcls_pkg::*; #(
    parameter int N_ENTRIES = 256,
    parameter int PROP_W    = 32,
    parameter int RING_N    = 8,
    localparam int IDX_W    = $clog2(N_ENTRIES),
    localparam int RING_W   = $clog2(RING_N)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            frame_start,
    input  logic [N_PROPS-1:0][PROP_W-1:0]  frame_props,
    input  logic                            filer_en,
    input  logic                            map_mode,
    input  logic [RING_N-1:0]               ring_en,
    input  logic                            idx_wr,
    input  logic [IDX_W-1:0]                idx_data,
    input  logic                            ctrl_wr,
    input  logic                            prop_wr,
    input  logic [PROP_W-1:0]               wr_data,
    output logic [PROP_W-1:0]               rd_ctrl,
    output logic [PROP_W-1:0]               rd_prop,
    output logic                            res_valid,
    output logic                            res_accept,
    output logic [QID_W-1:0]                res_queue,
    output logic [RING_W-1:0]               res_ring,
    output logic                            res_fiq_err,
    output logic                            res_nomatch
);
    localparam int PAIR_W = IDX_W - 1;
    localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(N_ENTRIES / 2 - 1);

    srch_state_e                    state_q, state_d;
    logic [PAIR_W-1:0]              pair_q;
    logic [N_PROPS-1:0][PROP_W-1:0] props_q;

    logic [1:0][IDX_W-1:0]          look_idx;
    rule_ctrl_t [1:0]               look_ctrl;
    logic [1:0][PROP_W-1:0]         look_prop;
    logic [1:0]                     lane_hit;
    logic                           any_hit, last_pair, win_rej, idle;
    logic [QID_W-1:0]               win_qid, map_qid;
    logic [RING_W-1:0]              map_ring;
    logic                           map_ok;
    logic [CTRL_W-1:0]              rd_ctrl_n;

    logic                           r_accept, r_fiq, r_nomatch;
    logic [QID_W-1:0]               r_queue;
    logic [RING_W-1:0]              r_ring;

    assign idle = (state_q == S_IDLE);

    rxcls_rule_table #(.N_ENTRIES(N_ENTRIES), .PROP_W(PROP_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (idle),
        .idx_wr     (idx_wr),
        .idx_data   (idx_data),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (wr_data[CTRL_W-1:0]),
        .prop_wr    (prop_wr),
        .prop_wdata (wr_data),
        .rd_ctrl    (rd_ctrl_n),
        .rd_prop    (rd_prop),
        .look_idx   (look_idx),
        .look_ctrl  (look_ctrl),
        .look_prop  (look_prop)
    );

    assign rd_ctrl = PROP_W'(rd_ctrl_n);

    // Two lanes: even entry of the pair on lane 0, odd entry on lane 1
    for (genvar l = 0; l < 2; l++) begin : g_lane
        assign look_idx[l] = {pair_q, 1'(l)};
        rxcls_rule_eval #(.PROP_W(PROP_W)) u_eval (
            .pid   (look_ctrl[l].pid),
            .op    (look_ctrl[l].op),
            .konst (look_prop[l]),
            .props (props_q),
            .hit   (lane_hit[l])
        );
    end

    always_comb begin
        any_hit   = |lane_hit;
        last_pair = (pair_q == LAST_PAIR);
        win_rej   = lane_hit[0] ? look_ctrl[0].reject : look_ctrl[1].reject;
        win_qid   = lane_hit[0] ? look_ctrl[0].qid    : look_ctrl[1].qid;
        map_qid   = (state_q == S_SEARCH) ? win_qid : '0;
    end

    rxcls_queue_map #(.RING_N(RING_N)) u_map (
        .qid_low     (map_qid[RING_W-1:0]),
        .single_ring (map_mode),
        .ring_en     (ring_en),
        .ring        (map_ring),
        .ring_ok     (map_ok)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (frame_start) state_d = filer_en ? S_SEARCH : S_REPORT;
            S_SEARCH: if (any_hit || last_pair) state_d = S_REPORT;
            S_REPORT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Search datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_q    <= '0;
            props_q   <= '0;
            r_accept  <= 1'b0;
            r_fiq     <= 1'b0;
            r_nomatch <= 1'b0;
            r_queue   <= '0;
            r_ring    <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (frame_start) begin
                        props_q   <= frame_props;
                        pair_q    <= '0;
                        r_accept  <= map_ok;
                        r_fiq     <= !map_ok;
                        r_nomatch <= 1'b0;
                        r_queue   <= '0;
                        r_ring    <= map_ring;
                    end
                end
                S_SEARCH: begin
                    pair_q <= pair_q + 1'b1;
                    if (any_hit) begin
                        r_nomatch <= 1'b0;
                        r_accept  <= !win_rej && map_ok;
                        r_fiq     <= !win_rej && !map_ok;
                        r_queue   <= win_rej ? '0 : win_qid;
                        r_ring    <= win_rej ? '0 : map_ring;
                    end else if (last_pair) begin
                        r_nomatch <= 1'b1;
                        r_accept  <= 1'b0;
                        r_fiq     <= 1'b0;
                        r_queue   <= '0;
                        r_ring    <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign res_valid   = (state_q == S_REPORT);
    assign res_accept  = r_accept;
    assign res_fiq_err = r_fiq;
    assign res_nomatch = r_nomatch;
    assign res_queue   = r_queue;
    assign res_ring    = r_ring;

    assert_single_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid)
        else $error("result strobe longer than one cycle");

    assert_accept_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_accept) |-> (!res_fiq_err && !res_nomatch))
        else $error("accepted frame carries an error flag");

    assert_pair_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEARCH && $past(state_q) == S_SEARCH) |-> (pair_q == $past(pair_q) + 1'b1))
        else $error("search skipped or repeated a pair");

    assert_report_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REPORT) |=> (state_q == S_IDLE))
        else $error("report did not return to idle");

    assert_ring_from_queue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_accept && res_ring != '0) |-> (res_ring == res_queue[RING_W-1:0]))
        else $error("ring does not follow queue bits");

    assert_reject_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_accept && !res_fiq_err && !res_nomatch) |-> (res_queue == '0 && res_ring == '0))
        else $error("rejected frame reports a queue");
endmodule

// File: tb/tb_rx_rule_classifier.sv
`timescale 1ns/1ps
module tb_rx_rule_classifier;
    logic              clk, rst_n;
    logic              frame_start, filer_en, map_mode;
    logic [15:0][31:0] frame_props;
    logic [7:0]        ring_en;
    logic              idx_wr, ctrl_wr, prop_wr;
    logic [7:0]        idx_data;
    logic [31:0]       wr_data, rd_ctrl, rd_prop;
    logic              res_valid, res_accept, res_fiq_err, res_nomatch;
    logic [5:0]        res_queue;
    logic [2:0]        res_ring;

    int n_chk = 0, n_err = 0;
    logic [12:0] m_ctrl [256];
    logic [31:0] m_prop [256];
    logic        e_acc, e_fiq, e_nm;
    logic [5:0]  e_q;
    logic [2:0]  e_ring;
    int          e_lat;
    longint      t_start;

    rx_rule_classifier dut (.*);

    initial clk = 1'b0;
    always #10 clk = ~clk;

    initial begin
        #(20 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int pid, int op, int rej, int q);
        return 32'((q << 7) | (rej << 6) | (op << 4) | pid);
    endfunction

    function automatic logic m_hit(logic [12:0] c, logic [31:0] k, logic [15:0][31:0] p);
        logic [31:0] v;
        v = p[c[3:0]];
        case (c[5:4])
            2'd0: return v == k;
            2'd1: return v != k;
            2'd2: return v >= k;
            default: return v < k;
        endcase
    endfunction

    task automatic model(input logic [15:0][31:0] p, input logic en, input logic mode, input logic [7:0] ren);
        if (!en) begin
            e_q = 0; e_ring = 0; e_acc = ren[0]; e_fiq = !ren[0]; e_nm = 0; e_lat = 1;
            return;
        end
        for (int i = 0; i < 256; i++) begin
            if (m_hit(m_ctrl[i], m_prop[i], p)) begin
                e_lat = i / 2 + 2; e_nm = 0;
                if (m_ctrl[i][6]) begin
                    e_acc = 0; e_q = 0; e_ring = 0; e_fiq = 0;
                end else begin
                    e_q = m_ctrl[i][12:7];
                    e_ring = mode ? 3'd0 : e_q[2:0];
                    e_acc = ren[e_ring]; e_fiq = !ren[e_ring];
                end
                return;
            end
        end
        e_acc = 0; e_q = 0; e_ring = 0; e_fiq = 0; e_nm = 1; e_lat = 129;
    endtask

    task automatic pulse_idx(input int i);
        idx_wr = 1; idx_data = 8'(i); @(negedge clk); idx_wr = 0;
    endtask
    task automatic pulse_ctrl(input logic [31:0] d);
        ctrl_wr = 1; wr_data = d; @(negedge clk); ctrl_wr = 0;
    endtask
    task automatic pulse_prop(input logic [31:0] d);
        prop_wr = 1; wr_data = d; @(negedge clk); prop_wr = 0;
    endtask
    task automatic wr_entry(input int i, input logic [31:0] c, input logic [31:0] k);
        pulse_idx(i); pulse_ctrl(c); pulse_prop(k);
        m_ctrl[i] = c[12:0]; m_prop[i] = k;
    endtask

    task automatic start_frame(input logic en, input logic mode, input logic [7:0] ren);
        filer_en = en; map_mode = mode; ring_en = ren;
        model(frame_props, en, mode, ren);
        frame_start = 1;
        @(posedge clk); t_start = $time;
        @(negedge clk); frame_start = 0;
    endtask

    task automatic finish_frame(input string tag);
        int guard = 0;
        int lat;
        while (!res_valid && guard < 400) begin @(negedge clk); guard++; end
        lat = int'(($time - t_start + 10) / 20);
        chk({tag, " latency"}, 64'(lat), 64'(e_lat));
        chk({tag, " accept"}, 64'(res_accept), 64'(e_acc));
        chk({tag, " queue"}, 64'(res_queue), 64'(e_q));
        chk({tag, " ring"}, 64'(res_ring), 64'(e_ring));
        chk({tag, " fiq_err"}, 64'(res_fiq_err), 64'(e_fiq));
        chk({tag, " nomatch"}, 64'(res_nomatch), 64'(e_nm));
        @(negedge clk);
        chk("R13 strobe width", 64'(res_valid), 64'd0);
    endtask

    task automatic run(input string tag, input logic en, input logic mode, input logic [7:0] ren);
        start_frame(en, mode, ren); finish_frame(tag);
    endtask

    task automatic fill_filler();
        for (int i = 0; i < 256; i++) wr_entry(i, 32'h0, 32'hDEAD_BEEF);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin m_ctrl[i] = 0; m_prop[i] = 0; end
        rst_n = 0; frame_start = 0; filer_en = 0; map_mode = 0; ring_en = 8'hFF;
        frame_props = '0; idx_wr = 0; idx_data = 0; ctrl_wr = 0; prop_wr = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk("R1 res_valid", 64'(res_valid), 64'd0);
        chk("R1 rd_ctrl", 64'(rd_ctrl), 64'd0);
        chk("R1 rd_prop", 64'(rd_prop), 64'd0);
        pulse_idx(255);
        chk("R1 rd_ctrl last", 64'(rd_ctrl), 64'd0);

        // R10: access and reserved bits
        wr_entry(5, 32'hFFFF_FFFF, 32'hA5A5_0F0F);
        pulse_idx(5);
        chk("R10 rd_ctrl", 64'(rd_ctrl), 64'h1FFF);
        chk("R10 rd_prop", 64'(rd_prop), 64'hA5A5_0F0F);

        fill_filler();
        frame_props = '0;

        // R9: bypass
        run("R9 bypass", 0, 0, 8'hFF);
        run("R9 bypass ring0 off", 0, 1, 8'hFE);

        // R8: no match
        run("R8 empty search", 1, 0, 8'hFF);

        // R2: pair priority
        frame_props[3] = 32'd7;
        wr_entry(10, mk(3, 0, 0, 5), 32'd7);
        wr_entry(11, mk(3, 0, 1, 0), 32'd7);
        run("R2 even wins file", 1, 0, 8'hFF);
        wr_entry(10, mk(3, 0, 1, 0), 32'd7);
        wr_entry(11, mk(3, 0, 0, 5), 32'd7);
        run("R2 even wins reject", 1, 0, 8'hFF);
        // R3: odd entry alone, then last entry
        wr_entry(10, 32'h0, 32'hDEAD_BEEF);
        wr_entry(11, mk(3, 0, 0, 9), 32'd7);
        run("R3 odd entry", 1, 0, 8'hFF);
        wr_entry(11, 32'h0, 32'hDEAD_BEEF);
        frame_props[1] = 32'h55;
        wr_entry(255, mk(1, 0, 0, 2), 32'h55);
        run("R3 last entry", 1, 0, 8'hFF);
        wr_entry(255, 32'h0, 32'hDEAD_BEEF);

        // R4: operators at boundaries, entry 40, property 2
        wr_entry(40, mk(2, 2, 0, 12), 32'd100);
        frame_props[2] = 32'd100; run("R4 ge equal", 1, 0, 8'hFF);
        frame_props[2] = 32'd99;  run("R4 ge below", 1, 0, 8'hFF);
        wr_entry(40, mk(2, 3, 0, 12), 32'd100);
        frame_props[2] = 32'd99;  run("R4 lt below", 1, 0, 8'hFF);
        frame_props[2] = 32'd100; run("R4 lt equal", 1, 0, 8'hFF);
        wr_entry(40, mk(2, 1, 0, 12), 32'd100);
        frame_props[2] = 32'd100; run("R4 ne equal", 1, 0, 8'hFF);
        frame_props[2] = 32'd101; run("R4 ne differ", 1, 0, 8'hFF);
        wr_entry(40, mk(2, 0, 0, 12), 32'd100);
        frame_props[2] = 32'd100; run("R4 eq equal", 1, 0, 8'hFF);
        wr_entry(40, mk(2, 2, 0, 12), 32'd1);
        frame_props[2] = 32'hFFFF_FFFF; run("R4 ge unsigned", 1, 0, 8'hFF);

        // R5, R6, R7
        wr_entry(40, mk(2, 0, 1, 33), 32'd100);
        frame_props[2] = 32'd100; run("R5 reject", 1, 0, 8'hFF);
        wr_entry(40, mk(2, 0, 0, 6'h2D), 32'd100);
        run("R6 mode0", 1, 0, 8'hFF);
        run("R6 mode1", 1, 1, 8'hFF);
        run("R7 ring off", 1, 0, 8'hDF);
        run("R7 mode1 ring0 on", 1, 1, 8'hDF);
        wr_entry(40, 32'h0, 32'hDEAD_BEEF);
        frame_props = '0;

        // R12: frame start while busy is dropped
        wr_entry(0, mk(6, 0, 0, 6), 32'h77);
        wr_entry(200, mk(5, 0, 0, 3), 32'h1234);
        frame_props[5] = 32'h1234;
        start_frame(1, 0, 8'hFF);
        repeat (3) @(negedge clk);
        frame_props[6] = 32'h77; frame_start = 1;
        @(negedge clk); frame_start = 0;
        finish_frame("R12 busy start");
        begin
            int extra = 0;
            for (int c = 0; c < 140; c++) begin
                if (res_valid) extra++;
                @(negedge clk);
            end
            chk("R12 extra strobes", 64'(extra), 64'd0);
        end
        frame_props[6] = 0;
        wr_entry(0, 32'h0, 32'hDEAD_BEEF);

        // R11: write during search is held off
        start_frame(1, 0, 8'hFF);
        pulse_idx(200);
        pulse_ctrl(mk(5, 0, 1, 0));
        finish_frame("R11 search uses old rule");
        repeat (3) @(negedge clk);
        pulse_idx(200);
        chk("R11 readback after idle", 64'(rd_ctrl), 64'(mk(5, 0, 1, 0)));
        m_ctrl[200] = 13'(mk(5, 0, 1, 0));
        run("R11 new rule applied", 1, 0, 8'hFF);

        // Random tables and frames (R2, R4, R6, R7)
        for (int t = 0; t < 3; t++) begin
            for (int i = 0; i < 256; i++) begin
                int op;
                op = ($urandom % 4 == 0) ? int'($urandom % 4) : 0;
                wr_entry(i, mk(int'($urandom % 16), op, ($urandom % 4 == 0) ? 1 : 0,
                               int'($urandom % 64)), 32'($urandom % 16));
            end
            for (int f = 0; f < 30; f++) begin
                for (int p = 0; p < 16; p++) frame_props[p] = 32'($urandom % 16);
                run("R2 random", ($urandom % 8) != 0, 1'($urandom % 2),
                    ($urandom % 2) ? 8'hFF : 8'($urandom));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule